// File: doc/BRIEF.md
# Isochronous Transmit Context Scheduler

Once per isochronous cycle this block walks through a fixed set of transmit contexts and moves one packet for each of the enabled ones from host memory into a transmit FIFO. A single cycle-start strobe launches the walk. For every enabled context the scheduler asks a bus-master port for a two-word descriptor. It reads the payload size and the payload address out of that descriptor, asks the bus for the payload, and pushes each returned word into the FIFO. When the last context is done it closes the cycle with a tagged marker word, so the downstream link logic can see where one cycle's traffic ends.

Disabled contexts are passed over without touching the bus. A zero-length descriptor yields no payload request. FIFO backpressure is passed back to the read-data handshake, so no payload word is dropped. A strobe that arrives while a walk is running is remembered and starts the next walk as soon as the marker has gone out.

Top module: `iso_tx_sched`

## Requirements
- R1: Each accepted cycle-start begins one walk that visits contexts in ascending index order, 0 to NUM_CTX-1. Each enabled context yields at most one packet per walk.
- R2: A context whose `ctx_active` bit is 0 when the walk reaches it causes no bus request and no FIFO write.
- R3: For an enabled context, the first request has address `DESC_BASE + index*DESC_STRIDE` and length 2 words. It is issued before any payload request for that context.
- R4: Bits [15:0] of the first descriptor word give the payload size in bytes, and bits above 15 are ignored. The second descriptor word gives the payload address. The payload request carries that address and a length of ceil(bytes/4) 32-bit words.
- R5: A descriptor with a byte count of 0 produces no payload request and no FIFO write for that context.
- R6: Payload words are written to the FIFO in the order the bus returns them, with `fifo_marker`=0. A word is written only in the cycle it is accepted from the bus.
- R7: After the last context, exactly one word is written with `fifo_marker`=1 and an all-zero payload. This ends the walk.
- R8: `rd_req`, `rd_addr` and `rd_len` stay asserted and unchanged until the cycle in which `rd_gnt` is high. A request transfers when `rd_req` and `rd_gnt` are both 1 at a clock edge.
- R9: `fifo_wr` is asserted only when `fifo_ready` is 1. During the payload phase, `rd_data_ready` follows `fifo_ready`, so no word is lost while the FIFO is full.
- R10: Cycle-start strobes that arrive during a walk are merged into one pending start. That start launches exactly one further walk right after the marker is written.
- R11: While `rst_n` is low, `rd_req` and `fifo_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | One-cycle strobe that starts a walk |
| ctx_active | input | NUM_CTX | Enable flag for each context |
| rd_req | output | 1 | Bus read request |
| rd_addr | output | AW | Byte address of the read |
| rd_len | output | LEN_W | Read length in 32-bit words |
| rd_gnt | input | 1 | Grant for the pending request |
| rd_data_valid | input | 1 | Read data word available |
| rd_data | input | DW | Read data word |
| rd_data_ready | output | 1 | Scheduler accepts the read data word |
| fifo_ready | input | 1 | FIFO can take a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_marker | output | 1 | 1 marks a cycle-marker word |
| fifo_wdata | output | DW | FIFO write payload |

## Verification
Some properties are checked by assertions on every cycle. A pending request must not change before its grant. No FIFO write may occur without FIFO ready. A marker word must have a zero payload. Each data write must coincide with an accepted bus beat. A skipped or zero-length context must issue no request. A pending start must relaunch the walk right after the marker. Other properties can only be shown by the bench's scenarios, which compare the full request list and FIFO stream of each walk against an arithmetic model. These are the ascending visit order, the descriptor decode with its word rounding, the skipping pattern over every enable mask, and the merging of several strobes that arrive mid-walk.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DREQ,
    ST_DRX,
    ST_PREQ,
    ST_PDATA,
    ST_MARK
  } sched_st_t;

  // Byte count rounded up to whole 32-bit words.
  function automatic logic [15:0] bytes_to_words(input logic [15:0] nbytes);
    logic [16:0] sum;
    sum = {1'b0, nbytes} + 17'd3;
    return {1'b0, sum[16:2]};
  endfunction

endpackage

// File: rtl/iso_tx_start_hold.sv
module iso_tx_start_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (take_i)
      pend_q <= 1'b0;
    else if (start_i && busy_i)
      pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/iso_tx_beat_cnt.sv
module iso_tx_beat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)
      cnt_q <= cnt_q - W'(1);
  end

  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/iso_tx_sched.sv
module iso_tx_sched
  import iso_tx_pkg::*;
#(
  parameter int            NUM_CTX     = 4,
  parameter int            AW          = 32,
  parameter int            DW          = 32,
  parameter int            LEN_W       = 16,
  parameter logic [AW-1:0] DESC_BASE   = 32'h0000_0100,
  parameter logic [AW-1:0] DESC_STRIDE = 32'h0000_0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cycle_start,
  input  logic [NUM_CTX-1:0] ctx_active,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr,
  output logic [LEN_W-1:0]   rd_len,
  input  logic               rd_gnt,
  input  logic               rd_data_valid,
  input  logic [DW-1:0]      rd_data,
  output logic               rd_data_ready,
  input  logic               fifo_ready,
  output logic               fifo_wr,
  output logic               fifo_marker,
  output logic [DW-1:0]      fifo_wdata
);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam logic [CTX_W-1:0] LAST_CTX = CTX_W'(NUM_CTX - 1);

  sched_st_t        st_q;
  logic [CTX_W-1:0] ctx_q;
  logic [15:0]      bytes_q;
  logic [AW-1:0]    paddr_q;
  logic             dword_q;

  // Named events, visible to the bound checker
  logic start_pend, start_take, busy;
  logic beat, data_push, ctx_skip_evt, zero_len_evt, pass_done_evt;
  logic desc_done, cnt_last, ctx_end, last_ctx;
  logic [15:0] words;

  function automatic logic [AW-1:0] desc_addr(input logic [CTX_W-1:0] idx);
    return DESC_BASE + (AW'(idx) * DESC_STRIDE);
  endfunction

  assign busy       = (st_q != ST_IDLE);
  assign start_take = (st_q == ST_IDLE) && (cycle_start || start_pend);
  assign last_ctx   = (ctx_q == LAST_CTX);
  assign words      = bytes_to_words(bytes_q);

  iso_tx_start_hold u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (cycle_start),
    .busy_i  (busy),
    .take_i  (start_take),
    .pend_o  (start_pend)
  );

  assign rd_req  = (st_q == ST_DREQ) || (st_q == ST_PREQ);
  assign rd_addr = (st_q == ST_DREQ) ? desc_addr(ctx_q) : paddr_q;
  assign rd_len  = (st_q == ST_DREQ) ? LEN_W'(2) : LEN_W'(words);

  assign rd_data_ready = (st_q == ST_DRX) || ((st_q == ST_PDATA) && fifo_ready);
  assign beat          = rd_data_valid && rd_data_ready;
  assign data_push     = (st_q == ST_PDATA) && beat;

  assign fifo_marker = (st_q == ST_MARK);
  assign fifo_wr     = data_push || ((st_q == ST_MARK) && fifo_ready);
  assign fifo_wdata  = (st_q == ST_MARK) ? '0 : rd_data;

  assign pass_done_evt = (st_q == ST_MARK) && fifo_ready;
  assign ctx_skip_evt  = (st_q == ST_SCAN) && !ctx_active[ctx_q];
  assign desc_done     = (st_q == ST_DRX) && beat && dword_q;
  assign zero_len_evt  = desc_done && (bytes_q == 16'd0);
  assign ctx_end       = ctx_skip_evt || zero_len_evt || (data_push && cnt_last);

  iso_tx_beat_cnt #(.W(16)) u_beats (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     ((st_q == ST_PREQ) && rd_gnt),
    .load_val_i (words),
    .dec_i      (data_push),
    .last_o     (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ctx_q   <= '0;
      bytes_q <= '0;
      paddr_q <= '0;
      dword_q <= 1'b0;
    end else begin
      if (ctx_end) begin
        if (last_ctx) begin
          st_q <= ST_MARK;
        end else begin
          ctx_q <= ctx_q + CTX_W'(1);
          st_q  <= ST_SCAN;
        end
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_take) begin
            ctx_q <= '0;
            st_q  <= ST_SCAN;
          end
          ST_SCAN: st_q <= ST_DREQ;
          ST_DREQ: if (rd_gnt) begin
            dword_q <= 1'b0;
            st_q    <= ST_DRX;
          end
          ST_DRX: if (beat) begin
            if (!dword_q) begin
              bytes_q <= rd_data[15:0];
              dword_q <= 1'b1;
            end else begin
              paddr_q <= rd_data[AW-1:0];
              st_q    <= ST_PREQ;
            end
          end
          ST_PREQ: if (rd_gnt) st_q <= ST_PDATA;
          ST_PDATA: ;
          ST_MARK: if (fifo_ready) st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/iso_tx_sched_chk.sv
module iso_tx_sched_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             rd_gnt,
  input logic [AW-1:0]    rd_addr,
  input logic [LEN_W-1:0] rd_len,
  input logic             rd_data_valid,
  input logic             rd_data_ready,
  input logic             fifo_ready,
  input logic             fifo_wr,
  input logic             fifo_marker,
  input logic [DW-1:0]    fifo_wdata,
  input logic             ctx_skip_evt,
  input logic             zero_len_evt,
  input logic             pass_done_evt,
  input logic             start_pend,
  input logic             start_take
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr) && $stable(rd_len));

  assert_no_write_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> fifo_ready);

  assert_marker_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr && fifo_marker |-> fifo_wdata == '0);

  assert_data_from_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr && !fifo_marker |-> rd_data_valid && rd_data_ready);

  assert_skip_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_skip_evt |-> !rd_req);

  assert_zero_len_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_len_evt |=> !rd_req);

  assert_pending_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done_evt && start_pend |=> start_take);
endmodule

bind iso_tx_sched iso_tx_sched_chk #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_req        (rd_req),
  .rd_gnt        (rd_gnt),
  .rd_addr       (rd_addr),
  .rd_len        (rd_len),
  .rd_data_valid (rd_data_valid),
  .rd_data_ready (rd_data_ready),
  .fifo_ready    (fifo_ready),
  .fifo_wr       (fifo_wr),
  .fifo_marker   (fifo_marker),
  .fifo_wdata    (fifo_wdata),
  .ctx_skip_evt  (ctx_skip_evt),
  .zero_len_evt  (zero_len_evt),
  .pass_done_evt (pass_done_evt),
  .start_pend    (start_pend),
  .start_take    (start_take)
);

// File: tb/iso_tx_sched_tb_top.sv
`timescale 1ns/1ps
module iso_tx_sched_tb_top;
  localparam int N = 4;
  localparam logic [31:0] DBASE  = 32'h0000_0100;
  localparam logic [31:0] DSTRD  = 32'h0000_0010;
  localparam logic [31:0] PBASE  = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_start = 1'b0;
  logic [N-1:0] ctx_active = '0;
  logic rd_req, rd_data_ready, fifo_wr, fifo_marker;
  logic [31:0] rd_addr, fifo_wdata;
  logic [15:0] rd_len;
  logic rd_gnt = 1'b0, rd_data_valid = 1'b0, fifo_ready = 1'b0;
  logic [31:0] rd_data = '0;

  always #5 clk = ~clk;

  iso_tx_sched #(.NUM_CTX(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .ctx_active(ctx_active),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .rd_gnt(rd_gnt),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data), .rd_data_ready(rd_data_ready),
    .fifo_ready(fifo_ready), .fifo_wr(fifo_wr), .fifo_marker(fifo_marker),
    .fifo_wdata(fifo_wdata)
  );

  int tests = 0, fails = 0, markers = 0, rmode = 0;
  logic [15:0] bytes_tab [N];
  logic [47:0] exp_req[$], got_req[$];
  logic [32:0] exp_fifo[$], got_fifo[$];

  function automatic logic [31:0] payload_addr(input int c);
    return PBASE + 32'(c) * 32'h1000;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int c;
    if (a >= PBASE) return {a[15:0], ~a[15:0]};
    c = int'((a - DBASE) >> 4);
    if (a[2]) return payload_addr(c);
    return {16'hBEEF ^ 16'(c), bytes_tab[c]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bus responder and FIFO monitor: inputs set at negedge, handshakes sampled 1 ns later
  initial begin
    int gnt_wait = 0, beats_left = 0, req_n = 0, cyc = 0;
    logic [31:0] beat_addr = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rd_gnt = 0; rd_data_valid = 0; fifo_ready = 0;
        continue;
      end
      rd_gnt        = rd_req && (gnt_wait == 0);
      rd_data_valid = (beats_left > 0) && !(rmode == 1 && cyc[0]);
      rd_data       = mem_word(beat_addr);
      fifo_ready    = (rmode == 0) ? 1'b1 : (cyc % 3 != 1);
      #1;
      if (rd_data_valid && rd_data_ready) begin
        beat_addr += 4;
        beats_left--;
      end
      if (rd_req && rd_gnt) begin
        got_req.push_back({rd_addr, rd_len});
        beat_addr  = rd_addr;
        beats_left = int'(rd_len);
        req_n++;
        gnt_wait = req_n % 3;
      end else if (rd_req && gnt_wait > 0) begin
        gnt_wait--;
      end
      if (fifo_wr) begin
        got_fifo.push_back({fifo_marker, fifo_wdata});
        if (fifo_marker) markers++;
      end
      cyc++;
    end
  end

  task automatic build_exp(input logic [N-1:0] mask);
    for (int c = 0; c < N; c++) begin
      if (mask[c]) begin
        int w;
        exp_req.push_back({DBASE + 32'(c) * DSTRD, 16'd2});
        w = (int'(bytes_tab[c]) + 3) / 4;
        if (w > 0) exp_req.push_back({payload_addr(c), 16'(w)});
        for (int i = 0; i < w; i++)
          exp_fifo.push_back({1'b0, mem_word(payload_addr(c) + 32'(4 * i))});
      end
    end
    exp_fifo.push_back({1'b1, 32'h0});
  endtask

  task automatic pulse_start();
    @(negedge clk); cycle_start = 1'b1;
    @(negedge clk); cycle_start = 1'b0;
  endtask

  task automatic wait_markers(input int target);
    int guard = 0;
    while (markers < target && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 5000, "R1 walk completes", 64'(markers), 64'(target));
    repeat (10) @(negedge clk);
  endtask

  task automatic compare_all();
    chk(got_req.size() == exp_req.size(), "R2 request count",
        64'(got_req.size()), 64'(exp_req.size()));
    for (int i = 0; i < exp_req.size() && i < got_req.size(); i++)
      chk(got_req[i] == exp_req[i], (exp_req[i][47:16] < PBASE) ? "R3 descriptor request" : "R4 payload request",
          64'(got_req[i]), 64'(exp_req[i]));
    chk(got_fifo.size() == exp_fifo.size(), "R1 FIFO word count",
        64'(got_fifo.size()), 64'(exp_fifo.size()));
    for (int i = 0; i < exp_fifo.size() && i < got_fifo.size(); i++)
      chk(got_fifo[i] == exp_fifo[i], exp_fifo[i][32] ? "R7 marker word" : "R6 data word",
          64'(got_fifo[i]), 64'(exp_fifo[i]));
  endtask

  task automatic run_pass(input logic [N-1:0] mask);
    got_req.delete(); exp_req.delete(); got_fifo.delete(); exp_fifo.delete();
    markers = 0;
    ctx_active = mask;
    build_exp(mask);
    pulse_start();
    wait_markers(1);
    compare_all();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(rd_req == 1'b0, "R11 no request in reset", 64'(rd_req), 64'd0);
    chk(fifo_wr == 1'b0, "R11 no write in reset", 64'(fifo_wr), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep every enable mask under both bus/FIFO pacing modes (R1, R2, R3, R4, R6, R7, R9)
    for (int m = 0; m < 2; m++) begin
      rmode = m;
      for (int mask = 0; mask < (1 << N); mask++) begin
        for (int c = 0; c < N; c++)
          bytes_tab[c] = 16'((mask * 7 + c * 11 + m * 3) % 23);
        run_pass(N'(mask));
      end
    end

    // R5: zero-length descriptors among non-zero ones
    rmode = 1;
    bytes_tab[0] = 16'd0; bytes_tab[1] = 16'd5; bytes_tab[2] = 16'd0; bytes_tab[3] = 16'd64;
    run_pass('1);
    begin
      int hits = 0;
      foreach (got_req[i])
        if (got_req[i][47:16] == payload_addr(0) || got_req[i][47:16] == payload_addr(2)) hits++;
      chk(hits == 0, "R5 no payload request for zero bytes", 64'(hits), 64'd0);
    end

    // R10: several strobes during a walk collapse into one further walk
    rmode = 0;
    for (int c = 0; c < N; c++) bytes_tab[c] = 16'(9 + c);
    got_req.delete(); exp_req.delete(); got_fifo.delete(); exp_fifo.delete();
    markers = 0;
    ctx_active = '1;
    build_exp('1);
    build_exp('1);
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (2) @(negedge clk);
    pulse_start();
    wait_markers(2);
    repeat (60) @(negedge clk);
    chk(markers == 2, "R10 merged strobes give one extra walk", 64'(markers), 64'd2);
    compare_all();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule